// File: doc/BRIEF.md
# Sliding-Window Event Rate Throttle

This block sits on a streaming path in front of a cipher engine that can only hold a small number of outstanding special operations. Every beat taken from the upstream source may carry three sideband flags: a tweak event, a ciphertext-stealing event and a decryption-key event. The block counts each class over its own sliding window of clock cycles. When any class reaches its limit, the block stops taking upstream beats. It then keeps the downstream link busy with filler encryption-key beats on a reserved channel until every class is back under its limit.

Outside a throttle episode, the upstream and downstream handshakes are joined combinationally, so a beat passes through with no added latency. A build-time bypass parameter removes the counting logic altogether and turns the block into plain wires.

Top module: `evt_rate_throttle`

## Requirements
- R1: Tweak events are limited to 4 inside a 20-cycle window. If the 4th tweak is accepted in cycle t, throttling is in force from cycle t+1.
- R2: Ciphertext-stealing events are limited to 3 inside a 20-cycle window, with the same one-cycle onset as R1.
- R3: Decryption-key events are limited to 4 inside a 16-cycle window, with the same one-cycle onset as R1.
- R4: While throttling, `s_ready` is low and no upstream beat is accepted.
- R5: While throttling, `m_valid` is high and the presented beat is a filler. A filler has `m_filler`=1, `m_chan`=1023 (selects the XTS profile), `m_data`=0, `m_last`=1, and all three event flags at 0.
- R6: An event accepted in cycle t counts against its class during cycles t+1 through t+W, where W is the window length of that class. Throttling ends in the first cycle in which every class count is below its limit.
- R7: An event is recorded only in a cycle where `s_valid` and `s_ready` are both high and the beat carries that class's flag.
- R8: Filler beats add nothing to any window count.
- R9: Downstream back-pressure is always honoured: `s_ready` is low whenever `m_ready` is low. A filler that has been presented and not yet accepted stays presented, even if the counts have already dropped below their limits.
- R10: When not throttling, `m_valid`, `m_data`, `m_chan`, `m_last` and the flags equal their upstream counterparts, `m_filler` is 0 and `s_ready` equals `m_ready`.
- R11: With `BYPASS`=1, the outputs always equal the corresponding inputs (`s_ready`=`m_ready`, `m_filler`=0), whatever the event history.
- R12: Synchronous reset clears all histories, counts and any pending filler, and leaves the block in pass-through.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| s_valid | input | 1 | Upstream beat valid |
| s_ready | output | 1 | Upstream beat ready |
| s_data | input | DATA_W | Upstream payload |
| s_chan | input | CHAN_W | Upstream channel number |
| s_last | input | 1 | Upstream end of packet |
| s_tweak | input | 1 | Beat carries a tweak event |
| s_cts | input | 1 | Beat carries a ciphertext-stealing event |
| s_dkey | input | 1 | Beat carries a decryption-key event |
| m_valid | output | 1 | Downstream beat valid |
| m_ready | input | 1 | Downstream beat ready |
| m_data | output | DATA_W | Downstream payload |
| m_chan | output | CHAN_W | Downstream channel number |
| m_last | output | 1 | Downstream end of packet |
| m_tweak | output | 1 | Forwarded tweak flag |
| m_cts | output | 1 | Forwarded ciphertext-stealing flag |
| m_dkey | output | 1 | Forwarded decryption-key flag |
| m_filler | output | 1 | Presented beat is a filler encryption-key beat |

## Verification
Pass-through results appear in the same cycle as their inputs, so the bench sets inputs just after a rising edge and compares the outputs at the following falling edge. The reference model stores the cycle number of each accepted event. For cycle c it counts the events of cycles c-W through c-1, so the onset of throttling is expected exactly one cycle after the limit-reaching acceptance, and the release exactly W+1 cycles after the oldest counted event. The held-filler state is modelled as "filler shown and `m_ready` low in the previous cycle". Directed episodes also count the filler beats accepted: 17 for back-to-back tweaks, 16 for ciphertext-stealing events two cycles apart and 13 for back-to-back decryption keys.

// File: rtl/thr_pkg.sv
package thr_pkg;
    localparam int NUM_CLASSES = 3;

    typedef enum logic [1:0] {
        EV_TWEAK = 2'd0,
        EV_CTS   = 2'd1,
        EV_DKEY  = 2'd2
    } ev_class_e;

    typedef struct packed {
        logic hold;
    } ctrl_state_t;
endpackage

// File: rtl/evt_window.sv
module evt_window #(
    parameter int W   = 20,
    parameter int THR = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic ev,
    output logic over
);
    localparam int CNT_W = $clog2(W + 1);

    typedef struct packed {
        logic [W-1:0]     hist;
        logic [CNT_W-1:0] cnt;
    } win_t;

    win_t win_d, win_q;

    always_comb begin
        win_d      = win_q;
        win_d.hist = {win_q.hist[W-2:0], ev};
        win_d.cnt  = win_q.cnt + CNT_W'(ev) - CNT_W'(win_q.hist[W-1]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            win_q <= '0;
        end else begin
            win_q <= win_d;
        end
    end

    assign over = (win_q.cnt >= CNT_W'(THR));

    assert_no_overflow_R6: assert property (@(posedge clk) disable iff (rst)
        win_q.cnt <= CNT_W'(W));

    assert_hist_count_R6: assert property (@(posedge clk) disable iff (rst)
        $countones(win_q.hist) == int'(win_q.cnt));
endmodule

// File: rtl/thr_ctrl.sv
module thr_ctrl
    import thr_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic [NUM_CLASSES-1:0] over,
    input  logic                   m_ready,
    output logic                   stall
);
    ctrl_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        stall     = (|over) | st_q.hold;
        st_d.hold = stall & ~m_ready;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assert_hold_filler_R9: assert property (@(posedge clk) disable iff (rst)
        (stall && !m_ready) |=> stall);
endmodule

// File: rtl/beat_mux.sv
module beat_mux #(
    parameter int DATA_W      = 64,
    parameter int CHAN_W      = 10,
    parameter int FILLER_CHAN = 1023
) (
    input  logic              stall,
    input  logic              s_valid,
    output logic              s_ready,
    input  logic [DATA_W-1:0] s_data,
    input  logic [CHAN_W-1:0] s_chan,
    input  logic              s_last,
    input  logic              s_tweak,
    input  logic              s_cts,
    input  logic              s_dkey,
    output logic              m_valid,
    input  logic              m_ready,
    output logic [DATA_W-1:0] m_data,
    output logic [CHAN_W-1:0] m_chan,
    output logic              m_last,
    output logic              m_tweak,
    output logic              m_cts,
    output logic              m_dkey,
    output logic              m_filler
);
    always_comb begin
        if (stall) begin
            s_ready  = 1'b0;
            m_valid  = 1'b1;
            m_data   = '0;
            m_chan   = CHAN_W'(FILLER_CHAN);
            m_last   = 1'b1;
            m_tweak  = 1'b0;
            m_cts    = 1'b0;
            m_dkey   = 1'b0;
            m_filler = 1'b1;
        end else begin
            s_ready  = m_ready;
            m_valid  = s_valid;
            m_data   = s_data;
            m_chan   = s_chan;
            m_last   = s_last;
            m_tweak  = s_tweak;
            m_cts    = s_cts;
            m_dkey   = s_dkey;
            m_filler = 1'b0;
        end
    end
endmodule

// File: rtl/evt_rate_throttle.sv
module evt_rate_throttle
    import thr_pkg::*;
#(
    parameter int DATA_W      = 64,
    parameter int CHAN_W      = 10,
    parameter int FILLER_CHAN = 1023,
    parameter int TWK_WIN     = 20,
    parameter int TWK_LIM     = 4,
    parameter int CTS_WIN     = 20,
    parameter int CTS_LIM     = 3,
    parameter int DKEY_WIN    = 16,
    parameter int DKEY_LIM    = 4,
    parameter bit BYPASS      = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              s_valid,
    output logic              s_ready,
    input  logic [DATA_W-1:0] s_data,
    input  logic [CHAN_W-1:0] s_chan,
    input  logic              s_last,
    input  logic              s_tweak,
    input  logic              s_cts,
    input  logic              s_dkey,
    output logic              m_valid,
    input  logic              m_ready,
    output logic [DATA_W-1:0] m_data,
    output logic [CHAN_W-1:0] m_chan,
    output logic              m_last,
    output logic              m_tweak,
    output logic              m_cts,
    output logic              m_dkey,
    output logic              m_filler
);
    localparam int WIN [NUM_CLASSES] = '{TWK_WIN, CTS_WIN, DKEY_WIN};
    localparam int LIM [NUM_CLASSES] = '{TWK_LIM, CTS_LIM, DKEY_LIM};

    if (BYPASS) begin : g_wire
        assign s_ready  = m_ready;
        assign m_valid  = s_valid;
        assign m_data   = s_data;
        assign m_chan   = s_chan;
        assign m_last   = s_last;
        assign m_tweak  = s_tweak;
        assign m_cts    = s_cts;
        assign m_dkey   = s_dkey;
        assign m_filler = 1'b0;
    end else begin : g_thr
        logic                   accept;
        logic [NUM_CLASSES-1:0] ev;
        logic [NUM_CLASSES-1:0] over;
        logic                   stall;

        always_comb begin
            accept       = s_valid & s_ready;
            ev[EV_TWEAK] = accept & s_tweak;
            ev[EV_CTS]   = accept & s_cts;
            ev[EV_DKEY]  = accept & s_dkey;
        end

        for (genvar g = 0; g < NUM_CLASSES; g++) begin : g_cls
            evt_window #(.W(WIN[g]), .THR(LIM[g])) u_win (
                .clk  (clk),
                .rst  (rst),
                .ev   (ev[g]),
                .over (over[g])
            );
        end

        thr_ctrl u_ctrl (
            .clk     (clk),
            .rst     (rst),
            .over    (over),
            .m_ready (m_ready),
            .stall   (stall)
        );

        beat_mux #(
            .DATA_W      (DATA_W),
            .CHAN_W      (CHAN_W),
            .FILLER_CHAN (FILLER_CHAN)
        ) u_mux (
            .stall    (stall),
            .s_valid  (s_valid),
            .s_ready  (s_ready),
            .s_data   (s_data),
            .s_chan   (s_chan),
            .s_last   (s_last),
            .s_tweak  (s_tweak),
            .s_cts    (s_cts),
            .s_dkey   (s_dkey),
            .m_valid  (m_valid),
            .m_ready  (m_ready),
            .m_data   (m_data),
            .m_chan   (m_chan),
            .m_last   (m_last),
            .m_tweak  (m_tweak),
            .m_cts    (m_cts),
            .m_dkey   (m_dkey),
            .m_filler (m_filler)
        );

        assert_no_accept_in_stall_R4: assert property (@(posedge clk) disable iff (rst)
            stall |-> !(s_valid && s_ready));

        assert_ready_gated_R9: assert property (@(posedge clk) disable iff (rst)
            !m_ready |-> !s_ready);

        assert_filler_kept_R9: assert property (@(posedge clk) disable iff (rst)
            (m_valid && m_filler && !m_ready) |=> (m_valid && m_filler));

        assert_filler_chan_R5: assert property (@(posedge clk) disable iff (rst)
            (m_valid && m_filler) |-> (m_chan == CHAN_W'(FILLER_CHAN)));
    end
endmodule

// File: tb/sim_evt_rate_throttle.sv
module sim_evt_rate_throttle;
    localparam int DW = 64;
    localparam int CW = 10;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic          rst, s_valid, s_last, s_tweak, s_cts, s_dkey, m_ready;
    logic [DW-1:0] s_data;
    logic [CW-1:0] s_chan;
    logic          s_ready, m_valid, m_last, m_tweak, m_cts, m_dkey, m_filler;
    logic [DW-1:0] m_data;
    logic [CW-1:0] m_chan;
    logic          b_ready, b_valid, b_last, b_tweak, b_cts, b_dkey, b_filler;
    logic [DW-1:0] b_data;
    logic [CW-1:0] b_chan;

    evt_rate_throttle #(.DATA_W(DW), .CHAN_W(CW)) u0 (
        .clk(clk), .rst(rst), .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
        .s_chan(s_chan), .s_last(s_last), .s_tweak(s_tweak), .s_cts(s_cts), .s_dkey(s_dkey),
        .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data), .m_chan(m_chan),
        .m_last(m_last), .m_tweak(m_tweak), .m_cts(m_cts), .m_dkey(m_dkey), .m_filler(m_filler));

    evt_rate_throttle #(.DATA_W(DW), .CHAN_W(CW), .BYPASS(1'b1)) u1 (
        .clk(clk), .rst(rst), .s_valid(s_valid), .s_ready(b_ready), .s_data(s_data),
        .s_chan(s_chan), .s_last(s_last), .s_tweak(s_tweak), .s_cts(s_cts), .s_dkey(s_dkey),
        .m_valid(b_valid), .m_ready(m_ready), .m_data(b_data), .m_chan(b_chan),
        .m_last(b_last), .m_tweak(b_tweak), .m_cts(b_cts), .m_dkey(b_dkey), .m_filler(b_filler));

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    int fill_cnt = 0;
    bit exp_hold = 1'b0;
    int twq[$];
    int ctq[$];
    int dkq[$];
    logic [DW-1:0] sbq[$];

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s cycle %0d: actual %0h expected %0h", tag, what, cyc, act, exp);
        end
    endtask

    function automatic int wcount(input int q[$], input int c, input int w);
        int n = 0;
        foreach (q[i]) if (q[i] >= c - w) n++;
        return n;
    endfunction

    // Monitor and reference model: inputs settle after posedge+1, compared at negedge.
    always @(negedge clk) begin
        if (rst) begin
            twq.delete(); ctq.delete(); dkq.delete(); sbq.delete();
            exp_hold = 1'b0;
        end else begin
            bit ot, oc, od, es, er;
            string tag;
            ot = wcount(twq, cyc, 20) >= 4;   // R1
            oc = wcount(ctq, cyc, 20) >= 3;   // R2
            od = wcount(dkq, cyc, 16) >= 4;   // R3
            es = ot | oc | od | exp_hold;     // R6, R9
            tag = ot ? "R1" : oc ? "R2" : od ? "R3" : exp_hold ? "R9" : "R6";
            er = m_ready && !es;
            chk(s_ready == er, es ? tag : "R9", "s_ready", s_ready, er);
            if (es) begin
                // R4 / R5: fillers while throttled
                chk(m_valid === 1'b1, "R4", "m_valid in stall", m_valid, 1);
                chk(m_filler === 1'b1 && m_chan == 10'd1023 && m_data == '0 && m_last === 1'b1,
                    "R5", "filler fields", {m_filler, m_chan}, {1'b1, 10'd1023});
                chk({m_tweak, m_cts, m_dkey} == 3'b000, "R5", "filler flags",
                    {m_tweak, m_cts, m_dkey}, 0);
                if (m_ready) fill_cnt++;
            end else begin
                // R10: pass-through
                chk(m_valid == s_valid && m_filler == 1'b0 && m_chan == s_chan &&
                    m_last == s_last && {m_tweak, m_cts, m_dkey} == {s_tweak, s_cts, s_dkey},
                    "R10", "pass fields", {m_valid, m_filler, m_chan}, {s_valid, 1'b0, s_chan});
                if (s_valid && er) sbq.push_back(s_data);
                if (m_valid && m_ready && sbq.size() > 0) begin
                    logic [DW-1:0] e;
                    e = sbq.pop_front();
                    chk(m_data == e, "R10", "scoreboard data", m_data, e);
                end
            end
            // R11: bypass instance is a wire
            chk(b_ready == m_ready && b_valid == s_valid && b_data == s_data && b_chan == s_chan &&
                b_last == s_last && {b_tweak, b_cts, b_dkey} == {s_tweak, s_cts, s_dkey} &&
                b_filler == 1'b0, "R11", "bypass", {b_ready, b_valid}, {m_ready, s_valid});
            // R7: only accepted beats carry events; R8: fillers never enter the queues
            if (s_valid && er) begin
                if (s_tweak) twq.push_back(cyc);
                if (s_cts)   ctq.push_back(cyc);
                if (s_dkey)  dkq.push_back(cyc);
            end
            while (twq.size() > 0 && twq[0] < cyc - 20) void'(twq.pop_front());
            while (ctq.size() > 0 && ctq[0] < cyc - 20) void'(ctq.pop_front());
            while (dkq.size() > 0 && dkq[0] < cyc - 16) void'(dkq.pop_front());
            exp_hold = es && !m_ready;
        end
        cyc++;
    end

    task automatic drive(input bit v, input bit tw, input bit ct, input bit dk, input bit mr);
        @(posedge clk);
        #1;
        s_valid = v; s_tweak = tw; s_cts = ct; s_dkey = dk; m_ready = mr;
        s_data = {$urandom, $urandom};
        s_chan = CW'($urandom_range(0, 1000));
        s_last = 1'($urandom);
    endtask

    task automatic idle(input int n, input bit v);
        for (int i = 0; i < n; i++) drive(v, 0, 0, 0, 1);
    endtask

    initial begin
        #(8 * 200000);
        fails++;
        checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        rst = 1'b1; s_valid = 0; s_tweak = 0; s_cts = 0; s_dkey = 0; m_ready = 0;
        s_data = '0; s_chan = '0; s_last = 0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        drive(1, 0, 0, 0, 1);
        #2;
        chk(s_ready === 1'b1 && m_filler === 1'b0, "R12", "after reset", {s_ready, m_filler}, 2'b10);

        // R1 (and R8): four back-to-back tweaks -> 17 fillers
        for (int i = 0; i < 4; i++) drive(1, 1, 0, 0, 1);
        fill_cnt = 0;
        idle(30, 1);
        chk(fill_cnt == 17, "R1", "tweak filler count (R8)", fill_cnt, 17);

        // R2: three CTS events two cycles apart -> 16 fillers
        fill_cnt = 0;
        for (int i = 0; i < 3; i++) begin
            drive(1, 0, 1, 0, 1);
            if (i < 2) drive(0, 0, 0, 0, 1);
        end
        idle(30, 1);
        chk(fill_cnt == 16, "R2", "cts filler count", fill_cnt, 16);

        // R3: four back-to-back decryption keys -> 13 fillers
        fill_cnt = 0;
        for (int i = 0; i < 4; i++) drive(1, 0, 0, 1, 1);
        idle(26, 1);
        chk(fill_cnt == 13, "R3", "dkey filler count", fill_cnt, 13);

        // R9: filler held after counts drop while downstream stalls
        for (int i = 0; i < 4; i++) drive(1, 1, 0, 0, 1);
        for (int i = 0; i < 30; i++) drive(1, 0, 0, 0, 0);
        #2;
        chk(m_filler === 1'b1 && s_ready === 1'b0, "R9", "held filler", {m_filler, s_ready}, 2'b10);
        idle(25, 1);

        // R7: flagged beats that are not accepted do not count
        for (int i = 0; i < 10; i++) drive(1, 1, 1, 1, 0);
        for (int i = 0; i < 3; i++) drive(1, 1, 0, 0, 1);
        fill_cnt = 0;
        idle(25, 1);
        chk(fill_cnt == 0, "R7", "no throttle below limit", fill_cnt, 0);

        // R12: reset in the middle of a throttle episode
        for (int i = 0; i < 4; i++) drive(1, 1, 0, 0, 1);
        idle(2, 1);
        @(posedge clk); #1 rst = 1'b1;
        drive(1, 0, 0, 0, 1);
        rst = 1'b0;
        #2;
        chk(s_ready === 1'b1 && m_filler === 1'b0, "R12", "reset mid-stall", {s_ready, m_filler}, 2'b10);
        idle(25, 1);

        // Mixed random traffic against the model
        for (int i = 0; i < 3000; i++)
            drive(($urandom_range(0, 9) < 8), ($urandom_range(0, 9) < 2), ($urandom_range(0, 9) < 1),
                  ($urandom_range(0, 9) < 2), ($urandom_range(0, 3) != 0));
        idle(30, 1);

        @(posedge clk);
        #2;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule